// File: doc/BRIEF.md
# Dual-Clock Mode-Selected Shift Register

This block is a small register whose contents change on falling edges of one of two slow control clocks. A mode line picks the clock that counts. When the mode line is low, falling edges of the shift clock move the contents one place toward the higher bit index, and a serial data bit enters at bit 0. When the mode line is high, falling edges of the load clock copy a parallel word into the register. Falling edges of the clock that is not selected do nothing.

The block runs on a single fast system clock. Both mode clocks are treated as ordinary asynchronous levels. Each passes through a synchronizer chain, and a falling edge is recognised when the synchronized level drops from 1 to 0 between two system cycles. The mode line and the data inputs are sampled on the system edge where the register updates.

A left shift is done outside the block by wiring output bit n to parallel input bit n-1, placing the new bit on the top parallel input, and pulsing the load clock. A wider right-shift chain is made by feeding the top output bit into the serial input of the next stage, with both stages sharing the clocks and the mode line.

Top module: `dual_clock_shreg`

## Requirements
- R1: While `rst` is high the register is forced to zero, and it reads zero on the cycle after any reset cycle.
- R2: With `mode_sel` = 0 (shift), a detected falling edge of `shift_clk` makes `q_out[0]` take `ser_in` and makes each `q_out[k]` take the old `q_out[k-1]`. The old top bit is lost.
- R3: With `mode_sel` = 1 (load), a detected falling edge of `load_clk` copies `par_in[k]` into `q_out[k]` for every k in one update.
- R4: A 1-to-0 change on a mode clock input, held stable, shows on `q_out` at the third rising `clk` edge after the change (two synchronizer stages plus the register). Rising edges of the mode clocks never change `q_out`.
- R5: A falling edge of the clock that `mode_sel` does not select leaves `q_out` unchanged.
- R6: When falling edges of both mode clocks are detected in the same cycle, only the operation that `mode_sel` selects is performed.
- R7: `mode_sel`, `ser_in` and `par_in` are taken at the system edge where the update happens, not at the time the mode clock fell.
- R8: A mode clock that is already low when reset is released does not count as a falling edge.
- R9: A mode clock held low for many cycles causes exactly one update.
- R10: Loading with `par_in` = {new bit, `q_out[WIDTH-1:1]`} performs a left shift: `q_out[k]` takes the old `q_out[k+1]`, and the top bit takes the new bit.
- R11: Two instances that share the clocks and `mode_sel`, with the second one's `ser_in` driven by the first one's `q_out[WIDTH-1]`, act as one right-shift register of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 selects shift on `shift_clk`, 1 selects load on `load_clk` |
| ser_in | input | 1 | Serial data that enters bit 0 on a shift |
| shift_clk | input | 1 | Asynchronous shift clock, acts on its falling edge |
| load_clk | input | 1 | Asynchronous load clock, acts on its falling edge |
| par_in | input | WIDTH | Parallel data copied on a load |
| q_out | output | WIDTH | Register contents |

## Verification
The bench targets the system edge where the update lands. A design with one synchronizer stage too few or too many changes `q_out` a cycle early or late. A design that acts on levels instead of edges keeps shifting while the clock is held low. It also drives falling edges on both clocks together, and edges on the clock that is not selected. A design that ORs the two edge strobes corrupts the register in both cases. It changes the mode line between the clock's fall and the update, so a design that latches the mode at the fall loads instead of shifting. It holds both clocks low through reset, so a detector with the wrong reset value produces a spurious update. Left-shift feedback and a two-stage cascade show the bit order at both ends of the register.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    typedef enum logic {
        SEL_SHIFT = 1'b0,
        SEL_LOAD  = 1'b1
    } sel_e;

    typedef struct packed {
        logic load_fall;
        logic shift_fall;
    } falls_t;

    localparam int CH_SHIFT = 0;
    localparam int CH_LOAD  = 1;
    localparam int NUM_CH   = 2;

    // Only the strobe of the selected channel may produce an operation.
    function automatic op_e pick_op(input sel_e sel, input falls_t f);
        op_e r;
        r = OP_HOLD;
        if (sel == SEL_SHIFT) begin
            if (f.shift_fall) r = OP_SHIFT;
        end else begin
            if (f.load_fall) r = OP_LOAD;
        end
        return r;
    endfunction

endpackage

// File: rtl/dcs_fall_det.sv
module dcs_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Reset to 0: a level that is already low after reset produces no strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= lvl_in;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[LAST];
        end
    end

    assign fall_o = last_q & ~sync_q[LAST];

endmodule

// File: rtl/dcs_shift_core.sv
module dcs_shift_core
    import dcs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                OP_SHIFT: q <= {q[TOP-1:0], ser_in};
                OP_LOAD:  q <= par_in;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/dual_clock_shreg.sv
module dual_clock_shreg
    import dcs_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             load_clk,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out
);
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] fall;
    falls_t            falls;
    op_e               op;
    logic              sh_fall;
    logic              ld_fall;

    assign lvl[CH_SHIFT] = shift_clk;
    assign lvl[CH_LOAD]  = load_clk;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_det
            dcs_fall_det #(.STAGES(SYNC_STAGES)) u_det (
                .clk    (clk),
                .rst    (rst),
                .lvl_in (lvl[c]),
                .fall_o (fall[c])
            );
        end
    endgenerate

    assign sh_fall          = fall[CH_SHIFT];
    assign ld_fall          = fall[CH_LOAD];
    assign falls.shift_fall = sh_fall;
    assign falls.load_fall  = ld_fall;
    assign op               = pick_op(sel_e'(mode_sel), falls);

    dcs_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser_in (ser_in),
        .par_in (par_in),
        .q      (q_out)
    );

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_sel,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out,
    input logic             sh_fall,
    input logic             ld_fall
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (q_out == '0));

    p_shift_right_r2: assert property (@(posedge clk) disable iff (rst)
        (sh_fall && !mode_sel) |=> (q_out == {$past(q_out[WIDTH-2:0]), $past(ser_in)}));

    p_load_word_r3: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && mode_sel) |=> (q_out == $past(par_in)));

    // R4: no strobe, no change
    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!sh_fall && !ld_fall) |=> $stable(q_out));

    p_unselected_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (sh_fall && !ld_fall && mode_sel) |=> $stable(q_out));

    p_unselected_load_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && !sh_fall && !mode_sel) |=> $stable(q_out));

    p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        sh_fall |=> !sh_fall);

    p_single_load_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        ld_fall |=> !ld_fall);

endmodule

bind dual_clock_shreg dcs_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .q_out    (q_out),
    .sh_fall  (sh_fall),
    .ld_fall  (ld_fall)
);

// File: tb/sim_dual_clock_shreg.sv
module sim_dual_clock_shreg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_sel = 1'b0;
    logic         ser_in = 1'b0;
    logic         shift_clk = 1'b0;
    logic         load_clk = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q_out;
    logic [W-1:0] q_out2;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  running  = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    dual_clock_shreg #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ser_in(ser_in),
        .shift_clk(shift_clk), .load_clk(load_clk), .par_in(par_in), .q_out(q_out)
    );

    // R11: second stage fed from the top bit of the first
    dual_clock_shreg #(.WIDTH(W)) u1 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ser_in(q_out[W-1]),
        .shift_clk(shift_clk), .load_clk(load_clk), .par_in(par_in), .q_out(q_out2)
    );

    // Behavioural reference: clock level history and expected contents.
    int           hs[3];
    int           hl[3];
    logic [W-1:0] mq;
    logic [W-1:0] mq2;
    bit           sf;
    bit           lf;

    always @(posedge clk) begin
        if (rst) begin
            foreach (hs[i]) begin hs[i] = 0; hl[i] = 0; end
            mq  = '0;
            mq2 = '0;
        end else begin
            sf = (hs[2] == 1) && (hs[1] == 0);
            lf = (hl[2] == 1) && (hl[1] == 0);
            if (!mode_sel && sf) begin
                mq2 = {mq2[W-2:0], mq[W-1]};
                mq  = {mq[W-2:0], ser_in};
            end else if (mode_sel && lf) begin
                mq  = par_in;
                mq2 = par_in;
            end
            hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = int'(shift_clk);
            hl[2] = hl[1]; hl[1] = hl[0]; hl[0] = int'(load_clk);
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            check("R2/R3 model stage0", {4'b0, q_out}, {4'b0, mq});
            check("R11 model stage1", {4'b0, q_out2}, {4'b0, mq2});
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit on_shift, input bit on_load);
        @(negedge clk);
        if (on_shift) shift_clk = 1'b0;
        if (on_load)  load_clk  = 1'b0;
        wait_n(5);
        shift_clk = 1'b1;
        load_clk  = 1'b1;
        wait_n(5);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    logic [W-1:0] snap;

    initial begin
        // R1 and R8: clocks held low through reset
        wait_n(4);
        check("R1 reset value", {4'b0, q_out}, 8'h00);
        @(negedge clk); rst = 1'b0; running = 1'b1;
        wait_n(8);
        check("R8 low clock at reset release", {4'b0, q_out}, 8'h00);
        shift_clk = 1'b1; load_clk = 1'b1;
        wait_n(5);
        check("R4 rising edges ignored", {4'b0, q_out}, 8'h00);

        // R2: right shifts, top bit discarded
        mode_sel = 1'b0;
        ser_in = 1'b1; pulse(1, 0); check("R2 shift 1", {4'b0, q_out}, 8'h01);
        ser_in = 1'b0; pulse(1, 0); check("R2 shift 2", {4'b0, q_out}, 8'h02);
        ser_in = 1'b1; pulse(1, 0); check("R2 shift 3", {4'b0, q_out}, 8'h05);
        ser_in = 1'b1; pulse(1, 0); check("R2 shift 4", {4'b0, q_out}, 8'h0B);
        ser_in = 1'b1; pulse(1, 0); check("R2 top bit lost", {4'b0, q_out}, 8'h07);

        // R3: parallel load
        mode_sel = 1'b1; par_in = 4'b1010;
        pulse(0, 1); check("R3 load", {4'b0, q_out}, 8'h0A);

        // R5: unselected clock edges
        ser_in = 1'b1; pulse(1, 0);
        check("R5 shift edge in load mode", {4'b0, q_out}, 8'h0A);
        mode_sel = 1'b0; par_in = 4'b0101; pulse(0, 1);
        check("R5 load edge in shift mode", {4'b0, q_out}, 8'h0A);

        // R4: update lands on the third rising edge
        ser_in = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
        wait_n(2);
        check("R4 not yet updated", {4'b0, q_out}, 8'h0A);
        wait_n(1);
        check("R4 updated on third edge", {4'b0, q_out}, 8'h05);
        wait_n(2); shift_clk = 1'b1; wait_n(6);
        check("R4 rise leaves value", {4'b0, q_out}, 8'h05);

        // R6: simultaneous edges
        mode_sel = 1'b0; ser_in = 1'b0; par_in = 4'b1111;
        pulse(1, 1); check("R6 both edges, shift selected", {4'b0, q_out}, 8'h0A);
        mode_sel = 1'b1; par_in = 4'b0011;
        pulse(1, 1); check("R6 both edges, load selected", {4'b0, q_out}, 8'h03);

        // R7: mode and data taken at the update edge
        mode_sel = 1'b1; ser_in = 1'b1; par_in = 4'b1111;
        @(negedge clk); shift_clk = 1'b0;
        wait_n(2); mode_sel = 1'b0; ser_in = 1'b0;
        wait_n(1);
        check("R7 late mode change", {4'b0, q_out}, 8'h06);
        wait_n(2); shift_clk = 1'b1; wait_n(5);

        // R9: clock held low gives one update
        ser_in = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
        wait_n(20);
        check("R9 held low single update", {4'b0, q_out}, 8'h0D);
        shift_clk = 1'b1; wait_n(5);

        // R10: left shift through feedback
        mode_sel = 1'b1;
        for (int k = 0; k < 3; k++) begin
            snap = q_out;
            par_in = {k[0], snap[W-1:1]};
            pulse(0, 1);
            check("R10 left shift", {4'b0, q_out}, {4'b0, k[0], snap[W-1:1]});
        end

        // R11: cascade of two stages
        @(negedge clk); rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(4);
        check("R1 reset mid-run", {q_out2, q_out}, 8'h00);
        mode_sel = 1'b1; par_in = 4'b1001; pulse(0, 1);
        mode_sel = 1'b0; ser_in = 1'b0;
        pulse(1, 0); pulse(1, 0);
        check("R11 cascade", {q_out2, q_out}, 8'b0110_0100);

        wait_n(3);
        running = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule